// File: doc/BRIEF.md
# Dual Ratio Clock Enable Divider

This block takes one fast source clock and derives two slower rates from it, a core rate and a peripheral rate. It does not generate new clock nets. Instead it produces clock-enable strobes that downstream logic qualifies its flops with. Each strobe is one source cycle wide and appears once per divided period. A strobe with a ratio of one stays high.

A single write port loads a 6-bit divider word. The core field picks a power-of-two ratio from 1 to 8. The peripheral field picks a linear ratio from 1 to 15.

Ratios are changed while the source clock runs. A written word is held pending. It becomes active on the first cycle in which both divider counters sit at their last count, so every period already in progress completes at its old length. The peripheral divider never runs faster than the core divider: a programmed peripheral ratio below the core ratio is raised to the core ratio, and a status bit reports this. A peripheral code of zero is rejected and raises a sticky error bit. Readback shows the active ratios, which are not the same as the pending ones.

Top module: `dualrate_clken_div`

## Requirements
- R1: After reset the core ratio reads 1, the peripheral ratio reads 5, and the pending, error and clamp bits are low. Both counters start at zero, so both enables are high in the first cycle after reset.
- R2: The core field is `wr_data[1:0]`. Codes 00, 01, 10 and 11 select divide by 1, 2, 4 and 8. `core_en` is high for one source cycle in every period of that length, and stays high continuously at ratio 1.
- R3: The peripheral field is `wr_data[5:2]`. A value N from 1 to 15 makes `peri_en` high for one source cycle every N cycles; with N=1 it is high continuously. For example, code 0110 gives 6 and code 1010 gives 10.
- R4: A write whose peripheral field is 0000 does not change the peripheral ratio. The value already pending is kept; if nothing is pending, the active value is kept. The core field of that write is still taken. `sel_err` goes high and stays high until reset.
- R5: The effective peripheral ratio is the larger of the programmed peripheral ratio and the core ratio. `clamp_flag` is high exactly when the programmed value is below the core ratio.
- R6: A write sets `rd_pending` from the next cycle. The pending word is applied at the first clock edge at which both counters are at their last count. In the following cycle both enables are high and `rd_pending` is low, unless another write arrived on that same edge.
- R7: `rd_core_ratio` and `rd_peri_ratio` show the active effective ratios. They change only when a pending word is applied.
- R8: A second write before the apply point replaces the pending word. Only the last word becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Loads `wr_data` into the pending divider word |
| wr_data | input | 6 | [1:0] core code, [5:2] peripheral ratio |
| core_en | output | 1 | Core-rate enable strobe |
| peri_en | output | 1 | Peripheral-rate enable strobe |
| rd_core_ratio | output | 4 | Active core ratio (1, 2, 4 or 8) |
| rd_peri_ratio | output | 4 | Active effective peripheral ratio |
| rd_pending | output | 1 | A written word waits to be applied |
| sel_err | output | 1 | Sticky: a zero peripheral code was written |
| clamp_flag | output | 1 | Peripheral ratio raised to the core ratio |

## Verification
The checker watches, on every cycle, the invariants that hold at any moment:
- the peripheral readback never drops below the core readback;
- a raised clamp bit means the two readbacks are equal;
- the core readback is a single power of two;
- the error bit, once set, stays set;
- the readbacks stay frozen while nothing is pending;
- both strobes fire right after a pending word lands.

The exact phase of each strobe depends on the order of writes relative to the joint wrap point, so only the bench's scenarios can show it. The same holds for a zero code kept across a pending replacement, for the clamped ratios actually driving the strobes, and for the last of two quick writes winning. The bench's cycle model covers these cases.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int CSEL_W  = 2;
  localparam int PSEL_W  = 4;
  localparam int RATIO_W = PSEL_W;

  typedef logic [RATIO_W-1:0] ratio_t;

  // power-of-two ratio from the core code
  function automatic ratio_t core_ratio(input logic [CSEL_W-1:0] code);
    return ratio_t'(1) << code;
  endfunction

  function automatic ratio_t ratio_max(input ratio_t a, input ratio_t b);
    return (a < b) ? b : a;
  endfunction
endpackage

// File: rtl/cdiv_rst_sync.sv
module cdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cdiv_lane_cnt.sv
module cdiv_lane_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ratio,
  output logic         pulse,
  output logic         at_last
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    at_last = (cnt_q >= (ratio - W'(1)));
    pulse   = (cnt_q == '0);
    cnt_d   = at_last ? '0 : (cnt_q + W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cdiv_ratio_ctrl.sv
module cdiv_ratio_ctrl #(
  parameter int CSEL_W     = 2,
  parameter int PSEL_W     = 4,
  parameter int RST_CSEL   = 0,
  parameter int RST_PRATIO = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CSEL_W-1:0] wr_csel,
  input  logic [PSEL_W-1:0] wr_psel,
  input  logic              wrap_both,
  output logic [CSEL_W-1:0] act_csel,
  output logic [PSEL_W-1:0] act_pratio,
  output logic              pending,
  output logic              err
);
  logic [CSEL_W-1:0] act_c_q, act_c_d, pnd_c_q, pnd_c_d;
  logic [PSEL_W-1:0] act_p_q, act_p_d, pnd_p_q, pnd_p_d;
  logic              pv_q, pv_d, err_q, err_d;
  logic              apply;
  logic              psel_zero;

  always_comb begin
    apply     = pv_q && wrap_both;
    psel_zero = (wr_psel == '0);
    act_c_d   = act_c_q;
    act_p_d   = act_p_q;
    pnd_c_d   = pnd_c_q;
    pnd_p_d   = pnd_p_q;
    pv_d      = pv_q;
    err_d     = err_q;
    if (apply) begin
      act_c_d = pnd_c_q;
      act_p_d = pnd_p_q;
      pv_d    = 1'b0;
    end
    if (wr_en) begin
      pnd_c_d = wr_csel;
      if (!psel_zero)  pnd_p_d = wr_psel;
      else if (!pv_q)  pnd_p_d = act_p_q;
      pv_d = 1'b1;
      if (psel_zero) err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_c_q <= CSEL_W'(RST_CSEL);
      act_p_q <= PSEL_W'(RST_PRATIO);
      pnd_c_q <= CSEL_W'(RST_CSEL);
      pnd_p_q <= PSEL_W'(RST_PRATIO);
      pv_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      act_c_q <= act_c_d;
      act_p_q <= act_p_d;
      pnd_c_q <= pnd_c_d;
      pnd_p_q <= pnd_p_d;
      pv_q    <= pv_d;
      err_q   <= err_d;
    end
  end

  assign act_csel   = act_c_q;
  assign act_pratio = act_p_q;
  assign pending    = pv_q;
  assign err        = err_q;
endmodule

// File: rtl/dualrate_clken_div.sv
module dualrate_clken_div
  import cdiv_pkg::*;
#(
  parameter int RST_CSEL   = 0,
  parameter int RST_PRATIO = 5,
  parameter int SYNC_STG   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [CSEL_W+PSEL_W-1:0]  wr_data,
  output logic                      core_en,
  output logic                      peri_en,
  output logic [RATIO_W-1:0]        rd_core_ratio,
  output logic [RATIO_W-1:0]        rd_peri_ratio,
  output logic                      rd_pending,
  output logic                      sel_err,
  output logic                      clamp_flag
);
  localparam int LANES = 2;

  logic              rst_n_int;
  logic [CSEL_W-1:0] act_csel;
  logic [PSEL_W-1:0] act_pratio;
  ratio_t            eff_core, eff_peri;
  ratio_t            lane_ratio [LANES];
  logic [LANES-1:0]  lane_pulse, lane_last;
  logic              wrap_both;

  cdiv_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  cdiv_ratio_ctrl #(
    .CSEL_W(CSEL_W), .PSEL_W(PSEL_W),
    .RST_CSEL(RST_CSEL), .RST_PRATIO(RST_PRATIO)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n_int), .wr_en(wr_en),
    .wr_csel(wr_data[CSEL_W-1:0]),
    .wr_psel(wr_data[CSEL_W+PSEL_W-1:CSEL_W]),
    .wrap_both(wrap_both),
    .act_csel(act_csel), .act_pratio(act_pratio),
    .pending(rd_pending), .err(sel_err)
  );

  always_comb begin
    eff_core      = core_ratio(act_csel);
    eff_peri      = ratio_max(ratio_t'(act_pratio), eff_core);
    lane_ratio[0] = eff_core;
    lane_ratio[1] = eff_peri;
    wrap_both     = &lane_last;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    cdiv_lane_cnt #(.W(RATIO_W)) u_cnt (
      .clk(clk), .rst_n(rst_n_int), .ratio(lane_ratio[g]),
      .pulse(lane_pulse[g]), .at_last(lane_last[g])
    );
  end

  assign core_en       = lane_pulse[0];
  assign peri_en       = lane_pulse[1];
  assign rd_core_ratio = eff_core;
  assign rd_peri_ratio = eff_peri;
  assign clamp_flag    = (ratio_t'(act_pratio) < eff_core);
endmodule

// File: rtl/dualrate_clken_div_chk.sv
module dualrate_clken_div_chk #(
  parameter int RW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_en,
  input logic          peri_en,
  input logic [RW-1:0] rd_core_ratio,
  input logic [RW-1:0] rd_peri_ratio,
  input logic          rd_pending,
  input logic          sel_err,
  input logic          clamp_flag
);
  // R5
  peri_not_faster_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_peri_ratio >= rd_core_ratio);

  // R5
  clamp_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_flag |-> (rd_peri_ratio == rd_core_ratio));

  // R2
  core_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rd_core_ratio) == 1);

  // R2
  core_unity_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_core_ratio == RW'(1)) |-> core_en);

  // R3
  peri_unity_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_peri_ratio == RW'(1)) |-> peri_en);

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |=> sel_err);

  // R7
  ratio_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_pending |=> ($stable(rd_core_ratio) && $stable(rd_peri_ratio)));

  // R6
  apply_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_pending) |-> (core_en && peri_en));
endmodule

bind dualrate_clken_div dualrate_clken_div_chk #(.RW(cdiv_pkg::RATIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_en(core_en), .peri_en(peri_en),
  .rd_core_ratio(rd_core_ratio), .rd_peri_ratio(rd_peri_ratio),
  .rd_pending(rd_pending), .sel_err(sel_err), .clamp_flag(clamp_flag)
);

// File: tb/dualrate_clken_div_tb_top.sv
`timescale 1ns/1ps
module dualrate_clken_div_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [5:0] wr_data = '0;
  logic       core_en, peri_en, rd_pending, sel_err, clamp_flag;
  logic [3:0] rd_core_ratio, rd_peri_ratio;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dualrate_clken_div dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .core_en(core_en), .peri_en(peri_en),
    .rd_core_ratio(rd_core_ratio), .rd_peri_ratio(rd_peri_ratio),
    .rd_pending(rd_pending), .sel_err(sel_err), .clamp_flag(clamp_flag)
  );

  // behavioural reference
  int s1, s2, ac, ap, pc_sel, pp, pv, er, cc, pcn;

  function automatic int m_cr();
    return 1 << ac;
  endfunction
  function automatic int m_pe();
    return (ap < m_cr()) ? m_cr() : ap;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 = 0; s2 = 0;
      ac = 0; ap = 5; pc_sel = 0; pp = 5; pv = 0; er = 0; cc = 0; pcn = 0;
    end else if (s2 == 0) begin
      s2 = s1; s1 = 1;
    end else begin
      int cr, pe, o_pv, o_ap, o_pp, wc, wp;
      bit cl, pl, app;
      cr = m_cr(); pe = m_pe();
      cl = (cc == cr - 1); pl = (pcn == pe - 1);
      app = (pv != 0) && cl && pl;
      o_pv = pv; o_ap = ap; o_pp = pp;
      cc = cl ? 0 : cc + 1;
      pcn = pl ? 0 : pcn + 1;
      if (app) begin ac = pc_sel; ap = o_pp; pv = 0; end
      if (wr_en) begin
        wc = int'(wr_data[1:0]); wp = int'(wr_data[5:2]);
        pc_sel = wc;
        if (wp != 0) pp = wp;
        else pp = (o_pv != 0) ? o_pp : o_ap;
        pv = 1;
        if (wp == 0) er = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(core_en == (cc == 0), "R2 core_en", core_en, cc == 0);
      chk(peri_en == (pcn == 0), "R3 peri_en", peri_en, pcn == 0);
      chk(int'(rd_core_ratio) == m_cr(), "R7 rd_core_ratio", rd_core_ratio, m_cr());
      chk(int'(rd_peri_ratio) == m_pe(), "R5 rd_peri_ratio", rd_peri_ratio, m_pe());
      chk(clamp_flag == (ap < m_cr()), "R5 clamp_flag", clamp_flag, ap < m_cr());
      chk(rd_pending == (pv != 0), "R6 rd_pending", rd_pending, pv);
      chk(sel_err == (er != 0), "R4 sel_err", sel_err, er);
    end
  end

  task automatic put(input int c, input int p);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = {4'(p), 2'(c)};
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!rd_pending) break;
    end
  endtask

  // a single write: readback stays on old ratios while pending (R6, R7)
  task automatic step_write(input int c, input int p);
    int oc, op;
    wait_idle();
    oc = rd_core_ratio; op = rd_peri_ratio;
    put(c, p);
    @(negedge clk);
    chk(rd_pending == 1'b1, "R6 pending after write", rd_pending, 1);
    chk(int'(rd_core_ratio) == oc, "R7 core ratio held", rd_core_ratio, oc);
    chk(int'(rd_peri_ratio) == op, "R7 peri ratio held", rd_peri_ratio, op);
    wait_idle();
  endtask

  task automatic gap(input bit use_peri, input int exp, input string req);
    int first, n;
    first = -1; n = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if ((use_peri ? peri_en : core_en) && !rd_pending) begin
        if (first >= 0) begin n = i - first; break; end
        first = i;
      end
    end
    chk(n == exp, req, n, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    cmp_on = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rd_core_ratio == 4'd1, "R1 core ratio", rd_core_ratio, 1);
    chk(rd_peri_ratio == 4'd5, "R1 peri ratio", rd_peri_ratio, 5);
    chk(!rd_pending && !sel_err && !clamp_flag, "R1 flags", {rd_pending, sel_err, clamp_flag}, 0);
    chk(core_en && peri_en, "R1 enables aligned", {core_en, peri_en}, 3);
    repeat (20) @(posedge clk);
    step_write(1, 6);                         // R2 R3 ratio 6
    gap(1'b1, 6, "R3 peri period 6");
    gap(1'b0, 2, "R2 core period 2");
    step_write(2, 10);                        // R3 ratio 10
    gap(1'b1, 10, "R3 peri period 10");
    gap(1'b0, 4, "R2 core period 4");
    step_write(0, 1);                         // both continuous
    chk(core_en && peri_en, "R3 ratio one high", {core_en, peri_en}, 3);
    step_write(3, 0);                         // R4 zero code, core 8, clamp
    chk(sel_err == 1'b1, "R4 error set", sel_err, 1);
    chk(rd_peri_ratio == 4'd8 && clamp_flag, "R5 clamp to core", rd_peri_ratio, 8);
    step_write(2, 3);                         // R5 clamp to 4
    chk(clamp_flag == 1'b1, "R5 clamp flag", clamp_flag, 1);
    chk(sel_err == 1'b1, "R4 error sticky", sel_err, 1);
    wait_idle();
    put(3, 15);                               // R8 replaced pending
    put(1, 7);
    wait_idle();
    chk(rd_core_ratio == 4'd2 && rd_peri_ratio == 4'd7, "R8 last write wins",
        {rd_core_ratio, rd_peri_ratio}, 8'h27);
    put(0, 9);                                // R4 zero while pending keeps 9
    put(1, 0);
    wait_idle();
    chk(rd_peri_ratio == 4'd9 && rd_core_ratio == 4'd2, "R4 pending peri kept",
        {rd_core_ratio, rd_peri_ratio}, 8'h29);
    repeat (40) @(posedge clk);
    done = 1'b1;
    cmp_on = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule